// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to one core's data cache port and decides whether a store-conditional may write. A load-linked goes to the cache as an ordinary read. The monitor also records the 64-byte line it touched as the core's single reservation. A later store-conditional is allowed to write only if that reservation is still live and covers the same line. The monitor then reports success (1) or failure (0) and drops the reservation in either case.

Several unrelated events can destroy a reservation at any time:
- a coherence invalidation that names the reserved line;
- an eviction of the reserved line;
- a context switch;
- a taken interrupt, when the interrupt-kill option is turned on.

The cache array, the coherence engine and the pipeline stay outside the block. It receives one request per cycle plus the event inputs. It drives a write-enable gate for the cache and a result bit for the store-conditional.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset no reservation exists and `wr_en`, `sc_done` and `sc_result` are 0, so a store-conditional issued first after reset fails.
- R2: A load-linked (`req_kind` = 2) records the line address `req_addr[ADDR_W-1:6]`. A later store-conditional (`req_kind` = 3) to any byte of that line succeeds. It gives `sc_result` = 1 and `wr_en` = 1.
- R3: A store-conditional whose line differs from the reserved line fails. It gives `sc_result` = 0 and `wr_en` = 0.
- R4: Every store-conditional, successful or not, clears the reservation, so a second one without a new load-linked fails.
- R5: A new load-linked replaces any earlier reservation with its own line.
- R6: An invalidation (`inv_valid`) naming the reserved line clears the reservation. An invalidation of another line leaves it intact.
- R7: An eviction (`evict_valid`) naming the reserved line clears the reservation. An eviction of another line leaves it intact.
- R8: A `ctx_switch` pulse clears the reservation.
- R9: An `irq_taken` pulse clears the reservation only while `irq_clear_en` is 1. Otherwise it has no effect.
- R10: A clearing event in the same cycle as a store-conditional wins, and the store-conditional fails. This covers an invalidation or eviction of the reserved line, a context switch, or an enabled interrupt. A clearing event in the same cycle as a load-linked leaves no reservation when it names the new line or clears unconditionally.
- R11: Plain loads (`req_kind` = 0) and plain stores (`req_kind` = 1) leave the reservation unchanged. A plain store always raises `wr_en`.
- R12: All outputs are registered and appear one cycle after the request. `sc_done` pulses only for a store-conditional, and `sc_result` is 0 in every cycle without `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| inv_valid | input | 1 | Coherence invalidation this cycle |
| inv_addr | input | ADDR_W | Address being invalidated |
| evict_valid | input | 1 | Eviction this cycle |
| evict_addr | input | ADDR_W | Address being evicted |
| ctx_switch | input | 1 | Context-switch pulse |
| irq_taken | input | 1 | Interrupt-taken pulse |
| irq_clear_en | input | 1 | Allows a taken interrupt to clear the reservation |
| wr_en | output | 1 | Cache write gate (plain store or successful store-conditional) |
| sc_done | output | 1 | A store-conditional completed |
| sc_result | output | 1 | 1 on store-conditional success, 0 on failure |

## Verification
The hardest situation to reach is a live, matching reservation meeting a store-conditional in exactly the cycle a clearing event arrives, because any earlier event or store-conditional silently removes it. The stimulus draws addresses from only four lines with random byte offsets, so random load-linked, store-conditional and snoop addresses collide often. Directed sequences also build a fresh reservation and then fire each clearing event alongside the store-conditional.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_LINK  = 2'd2,
    K_COND  = 2'd3
  } req_kind_e;
endpackage

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
  parameter int LINE_W = 26
) (
  input  logic              a_valid,
  input  logic [LINE_W-1:0] a_line,
  input  logic [LINE_W-1:0] b_line,
  output logic              hit
);
  always_comb hit = a_valid && (a_line == b_line);
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_link,
  input  logic [LINE_W-1:0] link_line,
  input  logic              link_killed,
  input  logic              cur_kill,
  input  logic              use_cond,
  output logic              resv_v,
  output logic [LINE_W-1:0] resv_line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resv_v    <= 1'b0;
      resv_line <= '0;
    end else if (set_link) begin
      resv_v    <= !link_killed;
      resv_line <= link_line;
    end else if (cur_kill || use_cond) begin
      resv_v    <= 1'b0;
    end
  end

  // R5: an unkilled load-linked always leaves a live reservation on its line
  a_r5_link_sets: assert property (@(posedge clk) disable iff (rst)
    (set_link && !link_killed) |=> (resv_v && resv_line == $past(link_line)));
endmodule

// File: rtl/llsc_out.sv
module llsc_out (
  input  logic clk,
  input  logic rst,
  input  logic is_store,
  input  logic is_cond,
  input  logic pass,
  output logic wr_en,
  output logic sc_done,
  output logic sc_result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      sc_done   <= 1'b0;
      sc_result <= 1'b0;
    end else begin
      wr_en     <= is_store || (is_cond && pass);
      sc_done   <= is_cond;
      sc_result <= is_cond && pass;
    end
  end

  // R12: a result is only reported together with a completion
  a_r12_result_needs_done: assert property (@(posedge clk) disable iff (rst)
    sc_result |-> sc_done);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              ctx_switch,
  input  logic              irq_taken,
  input  logic              irq_clear_en,
  output logic              wr_en,
  output logic              sc_done,
  output logic              sc_result
);
  import llsc_pkg::*;

  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFFS_W;
  localparam int N_CMP  = 5;
  localparam int C_INV_R = 0, C_EV_R = 1, C_INV_Q = 2, C_EV_Q = 3, C_REQ_R = 4;

  logic [LINE_W-1:0] req_line, inv_line, ev_line, resv_line;
  logic              resv_v;
  logic              is_link, is_cond, is_store;
  logic              global_kill, cur_kill, link_killed, pass;

  logic              cmp_v [N_CMP];
  logic [LINE_W-1:0] cmp_a [N_CMP];
  logic [LINE_W-1:0] cmp_b [N_CMP];
  logic [N_CMP-1:0]  hit;

  always_comb begin
    req_line = req_addr[ADDR_W-1:OFFS_W];
    inv_line = inv_addr[ADDR_W-1:OFFS_W];
    ev_line  = evict_addr[ADDR_W-1:OFFS_W];
    is_link  = req_valid && (req_kind_e'(req_kind) == K_LINK);
    is_cond  = req_valid && (req_kind_e'(req_kind) == K_COND);
    is_store = req_valid && (req_kind_e'(req_kind) == K_STORE);
    cmp_v[C_INV_R] = inv_valid;   cmp_a[C_INV_R] = inv_line; cmp_b[C_INV_R] = resv_line;
    cmp_v[C_EV_R]  = evict_valid; cmp_a[C_EV_R]  = ev_line;  cmp_b[C_EV_R]  = resv_line;
    cmp_v[C_INV_Q] = inv_valid;   cmp_a[C_INV_Q] = inv_line; cmp_b[C_INV_Q] = req_line;
    cmp_v[C_EV_Q]  = evict_valid; cmp_a[C_EV_Q]  = ev_line;  cmp_b[C_EV_Q]  = req_line;
    cmp_v[C_REQ_R] = resv_v;      cmp_a[C_REQ_R] = req_line; cmp_b[C_REQ_R] = resv_line;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    llsc_line_cmp #(.LINE_W(LINE_W)) i_cmp (
      .a_valid(cmp_v[g]), .a_line(cmp_a[g]), .b_line(cmp_b[g]), .hit(hit[g])
    );
  end

  always_comb begin
    global_kill = ctx_switch || (irq_taken && irq_clear_en);
    cur_kill    = global_kill || hit[C_INV_R] || hit[C_EV_R];
    link_killed = global_kill || hit[C_INV_Q] || hit[C_EV_Q];
    pass        = hit[C_REQ_R] && !cur_kill;
  end

  llsc_resv #(.LINE_W(LINE_W)) i_resv (
    .clk(clk), .rst(rst), .set_link(is_link), .link_line(req_line),
    .link_killed(link_killed), .cur_kill(cur_kill), .use_cond(is_cond),
    .resv_v(resv_v), .resv_line(resv_line)
  );

  llsc_out i_out (
    .clk(clk), .rst(rst), .is_store(is_store), .is_cond(is_cond), .pass(pass),
    .wr_en(wr_en), .sc_done(sc_done), .sc_result(sc_result)
  );

  // R3: with no live reservation a store-conditional cannot succeed
  a_r3_no_resv_fails: assert property (@(posedge clk) disable iff (rst)
    (is_cond && !resv_v) |=> (sc_done && !sc_result));
  // R4: a store-conditional always leaves the monitor empty
  a_r4_cond_clears: assert property (@(posedge clk) disable iff (rst)
    is_cond |=> !resv_v);
  // R8: context switch leaves no reservation
  a_r8_ctx_clears: assert property (@(posedge clk) disable iff (rst)
    ctx_switch |=> !resv_v);
  // R10: same-cycle invalidation of the target line defeats the store-conditional
  a_r10_inv_wins: assert property (@(posedge clk) disable iff (rst)
    (is_cond && inv_valid && inv_line == req_line) |=> !sc_result && !wr_en);
  // R12: completion pulses track store-conditional requests only
  a_r12_done_tracks: assert property (@(posedge clk) disable iff (rst)
    sc_done == $past(is_cond));
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int AW = 32;
  localparam int OFFS = 6;
  localparam realtime HALF = 2ns;

  logic clk = 0, rst = 1;
  logic req_valid = 0; logic [1:0] req_kind = 0; logic [AW-1:0] req_addr = 0;
  logic inv_valid = 0; logic [AW-1:0] inv_addr = 0;
  logic evict_valid = 0; logic [AW-1:0] evict_addr = 0;
  logic ctx_switch = 0, irq_taken = 0, irq_clear_en = 0;
  logic wr_en, sc_done, sc_result;

  int n_run = 0, n_fail = 0;
  bit m_v = 0; logic [AW-OFFS-1:0] m_line = '0;

  always #(HALF) clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .LINE_BYTES(64)) i_llsc_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .evict_valid(evict_valid),
    .evict_addr(evict_addr), .ctx_switch(ctx_switch), .irq_taken(irq_taken),
    .irq_clear_en(irq_clear_en), .wr_en(wr_en), .sc_done(sc_done), .sc_result(sc_result));

  function automatic logic [AW-OFFS-1:0] ln(input logic [AW-1:0] a);
    return a[AW-1:OFFS];
  endfunction

  function automatic logic [AW-1:0] mk(input int line, input int off);
    return 32'h4000_0000 + (line << OFFS) + off;
  endfunction

  task automatic idle();
    req_valid = 0; req_kind = 0; req_addr = 0; inv_valid = 0; evict_valid = 0;
    ctx_switch = 0; irq_taken = 0;
  endtask

  task automatic req(input int kind, input logic [AW-1:0] a);
    req_valid = 1; req_kind = kind[1:0]; req_addr = a;
  endtask

  // one cycle: inputs set by caller (at negedge); model, edge, check
  task automatic cyc(input string tag);
    bit gk, ck, lk, pass, e_wr, e_done, e_res;
    bit is_ll, is_sc, is_st;
    is_ll = req_valid && req_kind == 2;
    is_sc = req_valid && req_kind == 3;
    is_st = req_valid && req_kind == 1;
    gk = ctx_switch || (irq_taken && irq_clear_en);
    ck = gk || (inv_valid && ln(inv_addr) == m_line) || (evict_valid && ln(evict_addr) == m_line);
    lk = gk || (inv_valid && ln(inv_addr) == ln(req_addr)) || (evict_valid && ln(evict_addr) == ln(req_addr));
    pass = m_v && ln(req_addr) == m_line && !ck;
    e_wr = is_st || (is_sc && pass); e_done = is_sc; e_res = is_sc && pass;
    if (is_ll) begin m_v = !lk; m_line = ln(req_addr); end
    else if (ck || is_sc) m_v = 0;
    @(posedge clk); #1;
    n_run++;
    if (wr_en !== e_wr || sc_done !== e_done || sc_result !== e_res) begin
      n_fail++;
      $display("FAIL %s: wr/done/res actual %b%b%b expected %b%b%b", tag,
               wr_en, sc_done, sc_result, e_wr, e_done, e_res);
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit dummy;
    dummy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    n_run++;
    if (wr_en !== 0 || sc_done !== 0 || sc_result !== 0) begin
      n_fail++;
      $display("FAIL R1: outputs actual %b%b%b expected 000", wr_en, sc_done, sc_result);
    end
    idle();
    // R1: first SC after reset fails
    req(3, mk(0, 0)); cyc("R1");
    // R2: LL then SC to other byte of same line
    req(2, mk(1, 4)); cyc("R2"); req(3, mk(1, 60)); cyc("R2");
    // R4: second SC fails
    req(3, mk(1, 0)); cyc("R4");
    // R3: SC to other line
    req(2, mk(2, 0)); cyc("R3"); req(3, mk(3, 0)); cyc("R3");
    // R5: replacement
    req(2, mk(0, 0)); cyc("R5"); req(2, mk(2, 8)); cyc("R5");
    req(3, mk(0, 0)); cyc("R5");
    req(2, mk(0, 0)); cyc("R5"); req(2, mk(2, 8)); cyc("R5");
    req(3, mk(2, 1)); cyc("R5");
    // R6: invalidation of other line harmless, of reserved line kills
    req(2, mk(1, 0)); cyc("R6");
    inv_valid = 1; inv_addr = mk(2, 0); cyc("R6");
    req(3, mk(1, 0)); cyc("R6");
    req(2, mk(1, 0)); cyc("R6");
    inv_valid = 1; inv_addr = mk(1, 33); cyc("R6");
    req(3, mk(1, 0)); cyc("R6");
    // R7: eviction
    req(2, mk(3, 0)); cyc("R7");
    evict_valid = 1; evict_addr = mk(0, 0); cyc("R7");
    req(3, mk(3, 0)); cyc("R7");
    req(2, mk(3, 0)); cyc("R7");
    evict_valid = 1; evict_addr = mk(3, 5); cyc("R7");
    req(3, mk(3, 0)); cyc("R7");
    // R8: context switch
    req(2, mk(1, 0)); cyc("R8"); ctx_switch = 1; cyc("R8");
    req(3, mk(1, 0)); cyc("R8");
    // R9: interrupt with and without enable
    irq_clear_en = 0;
    req(2, mk(1, 0)); cyc("R9"); irq_taken = 1; cyc("R9");
    req(3, mk(1, 0)); cyc("R9");
    irq_clear_en = 1;
    req(2, mk(1, 0)); cyc("R9"); irq_taken = 1; cyc("R9");
    req(3, mk(1, 0)); cyc("R9");
    // R10: same-cycle kills
    req(2, mk(2, 0)); cyc("R10");
    req(3, mk(2, 0)); inv_valid = 1; inv_addr = mk(2, 7); cyc("R10");
    req(2, mk(2, 0)); cyc("R10");
    req(3, mk(2, 0)); evict_valid = 1; evict_addr = mk(2, 0); cyc("R10");
    req(2, mk(2, 0)); cyc("R10");
    req(3, mk(2, 0)); ctx_switch = 1; cyc("R10");
    req(2, mk(2, 0)); inv_valid = 1; inv_addr = mk(2, 0); cyc("R10");
    req(3, mk(2, 0)); cyc("R10");
    // R11: plain traffic leaves reservation, store writes
    req(2, mk(0, 0)); cyc("R11");
    req(0, mk(0, 0)); cyc("R11");
    req(1, mk(0, 4)); cyc("R11");
    req(3, mk(0, 0)); cyc("R11");
    // R12: idle cycle, no pulses
    cyc("R12");
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      req_valid = (k != 0);
      req_kind = (k < 3) ? 2'd0 : (k < 4) ? 2'd1 : (k < 7) ? 2'd2 : 2'd3;
      req_addr = mk($urandom_range(0, 3), $urandom_range(0, 63));
      inv_valid = ($urandom_range(0, 6) == 0); inv_addr = mk($urandom_range(0, 3), 0);
      evict_valid = ($urandom_range(0, 9) == 0); evict_addr = mk($urandom_range(0, 3), 3);
      ctx_switch = ($urandom_range(0, 19) == 0);
      irq_taken = ($urandom_range(0, 9) == 0);
      irq_clear_en = $urandom_range(0, 1);
      cyc(req_kind == 3 ? "R2_R10_random" : "R11_random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule